// File: doc/BRIEF.md
# One-Shot Pulse Timer with Locked Retrigger

This block is a 16-bit timer that produces one output pulse each time it is triggered. Two compare values set the pulse: the start compare sets the count at which the output goes high, and the end compare sets the count at which it goes low again. A trigger clears the counter and starts it. The trigger is either a software bit in the control register or a selected edge on an asynchronous external input, which passes through a two-flop synchronizer first.

Any trigger that arrives while a pulse is in flight is ignored. Each compare match raises its own single-cycle interrupt. A compare value of zero is flagged as a configuration error and blocks every start. The edge selection is locked while the timer runs. After the end match the counter holds its value until the next trigger.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, pulse_out, irq_end and irq_start are low, the mode is stopped (00), and cfg_err is high because both compare registers reset to zero.
- R2: Mode 00 (control bits [1:0]) stops the timer. No trigger starts a pulse in this mode. Writing 00 during a pulse drives pulse_out low on the clock after the write, without raising any interrupt.
- R3: Register map: address 0 is control, with mode in bits [1:0], edge select in bits [3:2] and the software trigger in bit 4. Address 1 is the end compare A and address 2 is the start compare B. Writing control with bit 4 set while mode is 01 starts a pulse. Counting the write edge as clock 1, pulse_out is high from clock B+2 and low again from clock A+2.
- R4: An external trigger edge applied before clock 1 starts the same pulse two clocks later than a software trigger (high from B+4, low from A+4), because it passes through the two-flop synchronizer.
- R5: Mode 01 accepts both the software bit and external edges. Modes 10 and 11 accept external edges only and ignore the software bit.
- R6: A software or external trigger that arrives while a pulse sequence is running is ignored; the pulse still ends at its original time.
- R7: irq_start is high for exactly one clock, on the clock where pulse_out rises. irq_end is high for exactly one clock, on the clock where the sequence ends. If A equals B, only irq_end fires and the pulse stays low.
- R8: cfg_err is high while either compare register holds zero, and every trigger is then ignored.
- R9: Writes to the edge-select field take effect only while the stored mode is 00; otherwise the field keeps its value.
- R10: After the end match the counter holds, and the next trigger produces a pulse with the same timing as the first.
- R11: Edge select encoding: 00 falling, 01 rising, 10 both edges, 11 no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 end compare, 2 start compare) |
| wr_data | input | 16 | Register write data |
| ext_trig | input | 1 | Asynchronous external trigger |
| pulse_out | output | 1 | One-shot pulse output |
| irq_end | output | 1 | Single-cycle interrupt on the end compare match |
| irq_start | output | 1 | Single-cycle interrupt on the start compare match |
| cfg_err | output | 1 | High while a compare register is zero |

## Verification
The table walks start and end compare pairs from a one-count-wide pulse to one 60 counts wide, and drives them through both the software bit and an external rising edge. The two-cycle difference between the two trigger paths is therefore checked against a common timing model. Directed cases add retriggers in the middle of a pulse by each path, which tells the lockout apart from a restart. They also cover the back-to-back pulses that follow the hold state, and equal compare values, which separate the two interrupts. Each edge-select code is tried with rising and falling input transitions, together with a locked edge-select write while running and zero compares. These show whether a start comes from the right edge, from a stale setting, or from an illegal configuration.

// File: rtl/ost_pkg.sv
package ost_pkg;

    typedef enum logic [1:0] {
        MODE_STOP  = 2'b00,
        MODE_SOFT  = 2'b01,
        MODE_HARD  = 2'b10,
        MODE_HARD2 = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ST_STOP,
        ST_FREE,
        ST_RUN,
        ST_HOLD
    } run_state_e;

    // control word layout, low bits of wr_data
    typedef struct packed {
        logic      sw_go;
        edge_sel_e edge_sel;
        mode_e     mode;
    } ctrl_word_t;

    localparam int CTRL_W         = 5;
    localparam int ADDR_CTRL      = 0;
    localparam int ADDR_CMP_END   = 1;
    localparam int ADDR_CMP_START = 2;

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prv);
        case (sel)
            EDGE_FALL: return prv & ~cur;
            EDGE_RISE: return cur & ~prv;
            EDGE_BOTH: return cur ^ prv;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic mode_takes_sw(mode_e m);
        return m == MODE_SOFT;
    endfunction

endpackage

// File: rtl/ost_trig_sync.sv
module ost_trig_sync
    import ost_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ext_trig,
    input  edge_sel_e edge_sel,
    output logic      trig_hit
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ext_trig};
            prev_q <= sync_q[TOP];
        end
    end

    assign trig_hit = edge_hit(edge_sel, sync_q[TOP], prev_q);

    // R11: no edge selected never produces a trigger
    p_none_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (edge_sel == EDGE_NONE) |-> !trig_hit);

    // R4: a trigger only appears where the synchronized level moved
    p_hit_on_change_r4: assert property (@(posedge clk) disable iff (rst)
        trig_hit |-> (sync_q[TOP] != prev_q));

endmodule

// File: rtl/ost_cfg_regs.sv
module ost_cfg_regs
    import ost_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output mode_e             mode,
    output edge_sel_e         edge_sel,
    output logic [CNT_W-1:0]  cmp_end,
    output logic [CNT_W-1:0]  cmp_start,
    output logic              sw_fire,
    output logic              cfg_err
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(ADDR_CMP_END);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(ADDR_CMP_START);

    ctrl_word_t ctrl_in;
    logic       ctrl_wr;

    assign ctrl_in = ctrl_word_t'(wr_data[CTRL_W-1:0]);
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_STOP;
            edge_sel  <= EDGE_FALL;
            cmp_end   <= '0;
            cmp_start <= '0;
        end else if (wr_en) begin
            if (ctrl_wr) begin
                mode <= ctrl_in.mode;
                if (mode == MODE_STOP)
                    edge_sel <= ctrl_in.edge_sel;
            end
            if (wr_addr == A_END)
                cmp_end <= wr_data;
            if (wr_addr == A_START)
                cmp_start <= wr_data;
        end
    end

    // software start judged against the mode in force before this write
    assign sw_fire = ctrl_wr && ctrl_in.sw_go && mode_takes_sw(mode);
    assign cfg_err = (cmp_end == '0) || (cmp_start == '0);

    // R9: edge select is frozen while the timer is not stopped
    p_edge_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_STOP) |=> $stable(edge_sel));

    // R5: software start never comes from the external-only modes
    p_sw_mode_r5: assert property (@(posedge clk) disable iff (rst)
        sw_fire |-> (mode == MODE_SOFT));

endmodule

// File: rtl/ost_pulse_core.sv
module ost_pulse_core
    import ost_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic             start_sw,
    input  logic             start_ext,
    input  logic             cfg_err,
    input  logic [CNT_W-1:0] cmp_end,
    input  logic [CNT_W-1:0] cmp_start,
    output logic             pulse_out,
    output logic             irq_end,
    output logic             irq_start
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             start_ok;
    logic             hit_end;
    logic             hit_start;

    assign armed     = (state == ST_FREE) || (state == ST_HOLD);
    assign start_ok  = armed && (mode != MODE_STOP) && !cfg_err
                       && (start_sw || start_ext);
    assign hit_end   = (cnt == cmp_end);
    assign hit_start = (cnt == cmp_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_STOP;
            cnt       <= '0;
            pulse_out <= 1'b0;
            irq_end   <= 1'b0;
            irq_start <= 1'b0;
        end else begin
            irq_end   <= 1'b0;
            irq_start <= 1'b0;
            if (mode == MODE_STOP) begin
                state     <= ST_STOP;
                cnt       <= '0;
                pulse_out <= 1'b0;
            end else begin
                case (state)
                    ST_STOP: begin
                        state <= ST_FREE;
                        cnt   <= '0;
                    end
                    ST_FREE, ST_HOLD: begin
                        if (start_ok) begin
                            state     <= ST_RUN;
                            cnt       <= '0;
                            pulse_out <= 1'b0;
                        end else if (state == ST_FREE) begin
                            cnt <= cnt + ONE;
                        end
                    end
                    default: begin
                        if (hit_end) begin
                            state     <= ST_HOLD;
                            pulse_out <= 1'b0;
                            irq_end   <= 1'b1;
                        end else begin
                            cnt <= cnt + ONE;
                            if (hit_start) begin
                                pulse_out <= 1'b1;
                                irq_start <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // R2: a stopped mode leaves the output low on the following clock
    p_stop_low_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STOP) |=> !pulse_out);

    // R7: the output rises only together with the start interrupt
    p_rise_irq_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_out) |-> irq_start);

    // R7: the output falls only at the end match or on a stop
    p_fall_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_out) |-> (irq_end || $past(mode) == MODE_STOP));

    // R7: each interrupt lasts a single clock
    p_irq_end_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq_end |=> !irq_end);
    p_irq_start_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq_start |=> !irq_start);

    // R6: a trigger in flight keeps the count moving rather than restarting it
    p_ignore_retrig_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && mode != MODE_STOP && !hit_end && (start_sw || start_ext))
        |=> (state == ST_RUN && cnt == $past(cnt) + ONE));

    // R8: a zero compare keeps the sequence from starting
    p_no_start_err_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN && cfg_err) |=> (state != ST_RUN));

    // R10: the counter holds between the end match and the next trigger
    p_hold_still_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && mode != MODE_STOP && !start_sw && !start_ext)
        |=> $stable(cnt));

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import ost_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ext_trig,
    output logic              pulse_out,
    output logic              irq_end,
    output logic              irq_start,
    output logic              cfg_err
);
    mode_e            mode;
    edge_sel_e        edge_sel;
    logic [CNT_W-1:0] cmp_end;
    logic [CNT_W-1:0] cmp_start;
    logic             sw_fire;
    logic             ext_hit;

    ost_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode      (mode),
        .edge_sel  (edge_sel),
        .cmp_end   (cmp_end),
        .cmp_start (cmp_start),
        .sw_fire   (sw_fire),
        .cfg_err   (cfg_err)
    );

    ost_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ext_trig (ext_trig),
        .edge_sel (edge_sel),
        .trig_hit (ext_hit)
    );

    ost_pulse_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .start_sw  (sw_fire),
        .start_ext (ext_hit),
        .cfg_err   (cfg_err),
        .cmp_end   (cmp_end),
        .cmp_start (cmp_start),
        .pulse_out (pulse_out),
        .irq_end   (irq_end),
        .irq_start (irq_start)
    );

endmodule

// File: tb/oneshot_timer_tb.sv
`timescale 1ns/1ps
module oneshot_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_trig = 1'b0;
    logic        pulse_out, irq_end, irq_start, cfg_err;

    always #2.5 clk = ~clk;

    oneshot_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_trig(ext_trig), .pulse_out(pulse_out),
        .irq_end(irq_end), .irq_start(irq_start), .cfg_err(cfg_err)
    );

    // encodings from R3, R5, R11
    localparam logic [1:0] M_STOP = 2'b00, M_SOFT = 2'b01, M_HARD = 2'b10;
    localparam logic [1:0] E_FALL = 2'b00, E_RISE = 2'b01, E_BOTH = 2'b10, E_NONE = 2'b11;
    localparam int K_NONE = 0, K_SW = 1, K_EXT = 2;

    // vector table: start compare B, end compare A, trigger kind
    localparam int NV = 6;
    localparam int V_B [NV] = '{3, 1, 5, 20, 100, 50};
    localparam int V_A [NV] = '{10, 2, 40, 21, 160, 52};
    localparam int V_K [NV] = '{K_SW, K_SW, K_EXT, K_EXT, K_SW, K_EXT};

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [1:0] cur_mode = M_STOP, cur_edge = E_FALL;
    int rise_at, fall_at, ia_at, ib_at, ia_cnt, ib_cnt;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] ctrl(input logic go, input logic [1:0] e, input logic [1:0] m);
        return {11'd0, go, e, m};
    endfunction

    task automatic setup(input logic [1:0] m, input logic [1:0] e, input int b, input int a);
        wr(2'd0, ctrl(1'b0, e, M_STOP));
        wr(2'd1, 16'(a));
        wr(2'd2, 16'(b));
        wr(2'd0, ctrl(1'b0, e, m));
        cur_mode = m; cur_edge = e;
        repeat (4) @(negedge clk);
    endtask

    task automatic drive(input int kind);
        if (kind == K_SW) begin
            wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctrl(1'b1, cur_edge, cur_mode);
        end else if (kind == K_EXT) begin
            ext_trig = ~ext_trig;
        end
    endtask

    // called at a negedge; clock n is the n-th posedge after the call
    task automatic watch(input int ncyc, input int kind, input int rt_kind, input int rt);
        rise_at = -1; fall_at = -1; ia_at = -1; ib_at = -1; ia_cnt = 0; ib_cnt = 0;
        drive(kind);
        for (int n = 1; n <= ncyc; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (pulse_out && rise_at < 0) rise_at = n;
            if (!pulse_out && rise_at >= 0 && fall_at < 0) fall_at = n;
            if (irq_end) begin ia_cnt++; ia_at = n; end
            if (irq_start) begin ib_cnt++; ib_at = n; end
            wr_en = 1'b0;
            if (n == rt) drive(rt_kind);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pulse", int'(pulse_out), 0);
        chk("R1 irq_end", int'(irq_end), 0);
        chk("R1 irq_start", int'(irq_start), 0);
        chk("R1 cfg_err", int'(cfg_err), 1);

        // table: main function under several compare pairs and both trigger paths (R3, R4, R7)
        for (int i = 0; i < NV; i++) begin
            int off;
            off = (V_K[i] == K_EXT) ? 4 : 2;
            ext_trig = 1'b0;
            setup(M_SOFT, E_RISE, V_B[i], V_A[i]);
            watch(V_A[i] + 8, V_K[i], K_NONE, 0);
            chk((V_K[i] == K_EXT) ? "R4 rise" : "R3 rise", rise_at, V_B[i] + off);
            chk((V_K[i] == K_EXT) ? "R4 fall" : "R3 fall", fall_at, V_A[i] + off);
            chk("R7 irq_end time", ia_at, V_A[i] + off);
            chk("R7 irq_start time", ib_at, V_B[i] + off);
            chk("R7 irq counts", ia_cnt * 10 + ib_cnt, 11);
        end
        ext_trig = 1'b0;

        // R8 zero compare blocks start
        wr(2'd0, ctrl(1'b0, E_RISE, M_STOP));
        wr(2'd1, 16'd10);
        wr(2'd2, 16'd0);
        wr(2'd0, ctrl(1'b0, E_RISE, M_SOFT));
        cur_mode = M_SOFT; cur_edge = E_RISE;
        repeat (4) @(negedge clk);
        chk("R8 cfg_err with zero", int'(cfg_err), 1);
        watch(30, K_SW, K_EXT, 3);
        chk("R8 no pulse on zero compare", rise_at, -1);
        chk("R8 no irq on zero compare", ia_cnt + ib_cnt, 0);
        ext_trig = 1'b0;
        wr(2'd2, 16'd4);
        chk("R8 cfg_err cleared", int'(cfg_err), 0);

        // R2 stopped mode ignores triggers
        setup(M_STOP, E_RISE, 2, 9);
        watch(30, K_EXT, K_NONE, 0);
        chk("R2 no pulse when stopped", rise_at, -1);
        ext_trig = 1'b0;
        // R2 stop in mid pulse
        setup(M_SOFT, E_RISE, 2, 50);
        watch(10, K_SW, K_NONE, 0);
        chk("R2 pulse high before stop", int'(pulse_out), 1);
        wr(2'd0, ctrl(1'b0, E_RISE, M_STOP));
        @(negedge clk);
        chk("R2 pulse low after stop", int'(pulse_out), 0);
        chk("R2 no irq on stop", int'(irq_end), 0);

        // R6 retrigger by software and by external edge
        setup(M_SOFT, E_RISE, 5, 30);
        watch(40, K_SW, K_SW, 8);
        chk("R6 sw retrigger ignored fall", fall_at, 32);
        chk("R6 sw retrigger single end", ia_cnt, 1);
        watch(40, K_SW, K_EXT, 10);
        chk("R6 ext retrigger ignored fall", fall_at, 32);
        chk("R6 ext retrigger rise", rise_at, 7);
        // R10 next trigger after the end gives the same pulse
        watch(40, K_SW, K_NONE, 0);
        chk("R10 repeat rise", rise_at, 7);
        chk("R10 repeat fall", fall_at, 32);
        ext_trig = 1'b0;

        // R5 external-only mode
        setup(M_HARD, E_RISE, 4, 9);
        watch(20, K_SW, K_NONE, 0);
        chk("R5 sw ignored in mode 10", rise_at, -1);
        watch(20, K_EXT, K_NONE, 0);
        chk("R5 ext accepted in mode 10", rise_at, 8);
        ext_trig = 1'b0;

        // R9 edge-select write while running is ignored
        setup(M_SOFT, E_RISE, 4, 9);
        wr(2'd0, ctrl(1'b0, E_FALL, M_SOFT));
        repeat (3) @(negedge clk);
        watch(20, K_EXT, K_NONE, 0);
        chk("R9 rising still selected", rise_at, 8);
        watch(20, K_EXT, K_NONE, 0);
        chk("R9 falling not taken", rise_at, -1);

        // R11 edge encodings
        setup(M_SOFT, E_FALL, 4, 9);
        watch(20, K_EXT, K_NONE, 0);
        chk("R11 falling select ignores rise", rise_at, -1);
        watch(20, K_EXT, K_NONE, 0);
        chk("R11 falling select takes fall", rise_at, 8);
        setup(M_SOFT, E_BOTH, 4, 9);
        watch(20, K_EXT, K_NONE, 0);
        chk("R11 both select takes rise", rise_at, 8);
        setup(M_SOFT, E_NONE, 4, 9);
        watch(20, K_EXT, K_NONE, 0);
        chk("R11 none select ignores fall", rise_at, -1);

        // R7 equal compares: end wins, no pulse
        setup(M_SOFT, E_NONE, 6, 6);
        watch(20, K_SW, K_NONE, 0);
        chk("R7 equal no pulse", rise_at, -1);
        chk("R7 equal irq_end time", ia_at, 8);
        chk("R7 equal no irq_start", ib_cnt, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule